// File: doc/BRIEF.md
# Load-Adaptive Motor Current Regulator

This block sets the coil current scale of a stepper driver from the load it measures. A stream of 10-bit load-margin samples comes in, each marked by a valid strobe. A large sample means the motor has torque to spare. A small sample means it is close to stalling. The block compares every valid sample with two thresholds taken from configuration.

When a sample is below the lower threshold, the current scale goes up at once by a configurable step. When samples sit at or above the upper threshold for a configurable number of consecutive valid samples, the scale goes down by one code. The scale never rises above the configured ceiling. It never falls below a floor, which is one half or one quarter of the ceiling.

The ceiling code `c` stands for a scale of `(c+1)/32`. Code 0 is 1/32 and code 31 is full current. Setting the lower threshold field to zero turns regulation off, and the output then follows the ceiling. The output is a registered 5-bit code that goes straight to the current DAC scaling path.

Top module: `load_adapt_current_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, `cur_scale` loads `cfg_ceil`. It stays there until the first valid sample after reset.
- R2: When `cfg_lo_thr` is 0, regulation is off. `cur_scale` equals the `cfg_ceil` of the previous cycle, and the consecutive-high count is cleared. After `cfg_lo_thr` becomes nonzero again, regulation restarts from the ceiling.
- R3: A valid sample strictly below `cfg_lo_thr*32` raises `cur_scale` on the next edge. The step is 1, 2, 4 or 8 for `cfg_inc_sel` codes 00, 01, 10 and 11. The result saturates at `cfg_ceil`.
- R4: The upper threshold is `(cfg_lo_thr + cfg_hi_ofs + 1)*32`. A sample equal to the upper threshold counts as high. A sample one below it does not count as high.
- R5: `cur_scale` drops by one code only on the valid high sample that completes a run of N consecutive valid high samples. N is 32, 8, 2 or 1 for `cfg_dec_spd` codes 00, 01, 10 and 11.
- R6: The floor code is `max(((cfg_ceil+1)>>1)-1, 0)` when `cfg_min_sel` is 0. It is `max(((cfg_ceil+1)>>2)-1, 0)` when `cfg_min_sel` is 1. A decrement never takes `cur_scale` below the floor.
- R7: The consecutive-high count restarts from zero in three cases: a valid sample lies below the upper threshold, a decrement has just happened, or regulation is off.
- R8: A cycle with `smp_vld` low leaves `cur_scale` and the consecutive-high count unchanged while regulation is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lo_thr | input | 4 | Lower threshold in units of 32; 0 turns regulation off |
| cfg_hi_ofs | input | 4 | Upper threshold offset above the lower one, in units of 32 |
| cfg_dec_spd | input | 2 | Selects how many consecutive high samples are needed per decrement |
| cfg_inc_sel | input | 2 | Selects the increment step for a low sample |
| cfg_min_sel | input | 1 | Floor select: 0 gives half of the ceiling, 1 gives a quarter |
| cfg_ceil | input | 5 | Current ceiling code, scale (code+1)/32 |
| smp_val | input | 10 | Load-margin sample |
| smp_vld | input | 1 | Sample valid strobe |
| cur_scale | output | 5 | Active current scale code |

## Verification
The consecutive-high count has no port of its own. A count that is wrong, or is not cleared, shows up only as a decrement on the wrong sample. With speed code 00 that can be as many as 32 valid samples after the fault. The bench therefore runs long unbroken high runs at every speed code, broken by samples that fall between the thresholds. A wrong threshold or floor shows up on the very next edge as a one-code difference in `cur_scale`. This is checked with directed samples placed exactly on each threshold and with decrements held against both floor choices.

// File: rtl/lacr_pkg.sv
package lacr_pkg;

  typedef enum logic [1:0] {
    CLS_IDLE = 2'd0,
    CLS_LOW  = 2'd1,
    CLS_MID  = 2'd2,
    CLS_HIGH = 2'd3
  } smp_class_e;

  // Increment step for the two-bit step select: 1, 2, 4, 8.
  function automatic int inc_step(input logic [1:0] code);
    return 1 << code;
  endfunction

  // Consecutive high samples needed per decrement: 32, 8, 2, 1.
  function automatic int dec_need(input logic [1:0] code);
    case (code)
      2'b00:   return 32;
      2'b01:   return 8;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/lacr_thresh.sv
module lacr_thresh
  import lacr_pkg::*;
#(
  parameter int SMP_W = 10,
  parameter int THR_W = 4,
  parameter int SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [THR_W-1:0] lo_thr,
  input  logic [THR_W-1:0] hi_ofs,
  input  logic [SMP_W-1:0] smp_val,
  input  logic             smp_vld,
  output logic             reg_en,
  output smp_class_e       smp_cls
);

  localparam int SUM_W = THR_W + 1;
  localparam int LIM_W = SUM_W + SHIFT + 1;

  logic [SUM_W-1:0] hi_units;
  logic [LIM_W-1:0] lo_lim;
  logic [LIM_W-1:0] hi_lim;
  logic [LIM_W-1:0] smp_ext;

  always_comb begin
    hi_units = {1'b0, lo_thr} + {1'b0, hi_ofs} + SUM_W'(1);
    lo_lim   = LIM_W'(lo_thr) << SHIFT;
    hi_lim   = LIM_W'(hi_units) << SHIFT;
    smp_ext  = LIM_W'(smp_val);
    reg_en   = (lo_thr != '0);
  end

  always_comb begin
    if (!smp_vld || !reg_en)      smp_cls = CLS_IDLE;
    else if (smp_ext < lo_lim)    smp_cls = CLS_LOW;
    else if (smp_ext >= hi_lim)   smp_cls = CLS_HIGH;
    else                          smp_cls = CLS_MID;
  end

  // R4
  thr_order_chk: assert property (@(posedge clk) disable iff (rst)
    hi_lim >= lo_lim + (LIM_W'(1) << SHIFT));

endmodule

// File: rtl/lacr_hold_cnt.sv
module lacr_hold_cnt
  import lacr_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_en,
  input  smp_class_e smp_cls,
  input  logic [1:0] dec_spd,
  output logic       dec_fire
);

  localparam int CW1 = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CW1-1:0]   cnt_inc;
  logic [CW1-1:0]   need_v;
  logic             hit;

  always_comb begin
    hit      = (smp_cls == CLS_HIGH);
    cnt_inc  = {1'b0, cnt_q} + CW1'(1);
    need_v   = CW1'(dec_need(dec_spd));
    dec_fire = hit && (cnt_inc >= need_v);
  end

  always_ff @(posedge clk) begin
    if (rst || !reg_en) begin
      cnt_q <= '0;
    end else if (hit) begin
      cnt_q <= dec_fire ? '0 : cnt_inc[CNT_W-1:0];
    end else if (smp_cls != CLS_IDLE) begin
      cnt_q <= '0;
    end
  end

  // R5
  run_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !dec_fire) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R7
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_fire || smp_cls == CLS_LOW || smp_cls == CLS_MID || !reg_en) |=> (cnt_q == '0));

  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_en && smp_cls == CLS_IDLE) |=> $stable(cnt_q));

endmodule

// File: rtl/lacr_step.sv
module lacr_step
  import lacr_pkg::*;
#(
  parameter int SCL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_en,
  input  smp_class_e       smp_cls,
  input  logic             dec_fire,
  input  logic [SCL_W-1:0] ceil_code,
  input  logic             min_sel,
  input  logic [1:0]       inc_sel,
  output logic [SCL_W-1:0] cur_scale
);

  localparam int EXT_W = SCL_W + 4;

  logic [SCL_W:0]   ceil_p1;
  logic [SCL_W:0]   frac_q;
  logic [SCL_W-1:0] floor_code;
  logic [EXT_W-1:0] inc_sum;
  logic [SCL_W-1:0] inc_next;
  logic [SCL_W-1:0] dec_next;
  logic [SCL_W-1:0] cur_q;

  always_comb begin
    ceil_p1    = {1'b0, ceil_code} + (SCL_W+1)'(1);
    frac_q     = min_sel ? (ceil_p1 >> 2) : (ceil_p1 >> 1);
    floor_code = (frac_q == '0) ? '0 : SCL_W'(frac_q - (SCL_W+1)'(1));
    inc_sum    = EXT_W'(cur_q) + EXT_W'(inc_step(inc_sel));
    inc_next   = (inc_sum > EXT_W'(ceil_code)) ? ceil_code : inc_sum[SCL_W-1:0];
    dec_next   = (cur_q > floor_code) ? (cur_q - SCL_W'(1)) : floor_code;
  end

  always_ff @(posedge clk) begin
    if (rst || !reg_en) begin
      cur_q <= ceil_code;
    end else if (smp_cls == CLS_LOW) begin
      cur_q <= inc_next;
    end else if (dec_fire) begin
      cur_q <= dec_next;
    end
  end

  assign cur_scale = cur_q;

  // R2
  off_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_en |=> (cur_q == $past(ceil_code)));

  // R3
  inc_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_cls == CLS_LOW) |=> (cur_q <= $past(ceil_code)));

  // R6
  dec_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_fire && cur_q > floor_code) |=> (cur_q == $past(cur_q) - SCL_W'(1)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_en && smp_cls == CLS_IDLE) |=> $stable(cur_q));

endmodule

// File: rtl/load_adapt_current_reg.sv
module load_adapt_current_reg
  import lacr_pkg::*;
#(
  parameter int SMP_W = 10,
  parameter int THR_W = 4,
  parameter int SCL_W = 5,
  parameter int SHIFT = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [THR_W-1:0] cfg_lo_thr,
  input  logic [THR_W-1:0] cfg_hi_ofs,
  input  logic [1:0]       cfg_dec_spd,
  input  logic [1:0]       cfg_inc_sel,
  input  logic             cfg_min_sel,
  input  logic [SCL_W-1:0] cfg_ceil,
  input  logic [SMP_W-1:0] smp_val,
  input  logic             smp_vld,
  output logic [SCL_W-1:0] cur_scale
);

  logic       reg_en;
  smp_class_e smp_cls;
  logic       dec_fire;

  lacr_thresh #(
    .SMP_W(SMP_W), .THR_W(THR_W), .SHIFT(SHIFT)
  ) thresh_i (
    .clk(clk), .rst(rst), .lo_thr(cfg_lo_thr), .hi_ofs(cfg_hi_ofs),
    .smp_val(smp_val), .smp_vld(smp_vld), .reg_en(reg_en), .smp_cls(smp_cls)
  );

  lacr_hold_cnt #(.CNT_W(CNT_W)) hold_i (
    .clk(clk), .rst(rst), .reg_en(reg_en), .smp_cls(smp_cls),
    .dec_spd(cfg_dec_spd), .dec_fire(dec_fire)
  );

  lacr_step #(.SCL_W(SCL_W)) step_i (
    .clk(clk), .rst(rst), .reg_en(reg_en), .smp_cls(smp_cls),
    .dec_fire(dec_fire), .ceil_code(cfg_ceil), .min_sel(cfg_min_sel),
    .inc_sel(cfg_inc_sel), .cur_scale(cur_scale)
  );

  // R5
  fire_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
    dec_fire |-> (smp_vld && reg_en));

  // R1
  reset_load_chk: assert property (@(posedge clk)
    rst |=> (cur_scale == $past(cfg_ceil)));

endmodule

// File: tb/load_adapt_current_reg_tb_top.sv
`timescale 1ns/1ps
module load_adapt_current_reg_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] cfg_lo_thr, cfg_hi_ofs;
  logic [1:0] cfg_dec_spd, cfg_inc_sel;
  logic       cfg_min_sel;
  logic [4:0] cfg_ceil;
  logic [9:0] smp_val;
  logic       smp_vld;
  logic [4:0] cur_scale;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_cur = 0;
  int exp_cnt = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  load_adapt_current_reg dut_i (
    .clk(clk), .rst(rst), .cfg_lo_thr(cfg_lo_thr), .cfg_hi_ofs(cfg_hi_ofs),
    .cfg_dec_spd(cfg_dec_spd), .cfg_inc_sel(cfg_inc_sel), .cfg_min_sel(cfg_min_sel),
    .cfg_ceil(cfg_ceil), .smp_val(smp_val), .smp_vld(smp_vld), .cur_scale(cur_scale)
  );

  function automatic int lo_lim_f();
    return int'(cfg_lo_thr) * 32;
  endfunction
  function automatic int hi_lim_f();
    return (int'(cfg_lo_thr) + int'(cfg_hi_ofs) + 1) * 32;
  endfunction
  function automatic int need_f();
    case (cfg_dec_spd)
      2'b00: return 32;
      2'b01: return 8;
      2'b10: return 2;
      default: return 1;
    endcase
  endfunction
  function automatic int floor_f();
    int q;
    q = cfg_min_sel ? ((int'(cfg_ceil) + 1) / 4) : ((int'(cfg_ceil) + 1) / 2);
    return (q == 0) ? 0 : q - 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: cur_scale=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: inputs already set at the falling edge; model advances, then compare.
  task automatic tick(input string force_tag);
    string tag;
    int s;
    s = int'(smp_val);
    @(posedge clk);
    #1;
    if (cfg_lo_thr == 0) begin
      tag = "R2"; exp_cur = int'(cfg_ceil); exp_cnt = 0;
    end else if (!smp_vld) begin
      tag = "R8";
    end else if (s < lo_lim_f()) begin
      tag = "R3"; exp_cnt = 0;
      exp_cur = exp_cur + (1 << cfg_inc_sel);
      if (exp_cur > int'(cfg_ceil)) exp_cur = int'(cfg_ceil);
    end else if (s >= hi_lim_f()) begin
      tag = (s == hi_lim_f()) ? "R4" : "R5";
      exp_cnt++;
      if (exp_cnt >= need_f()) begin
        exp_cnt = 0;
        if (exp_cur > floor_f()) exp_cur--;
        else begin exp_cur = floor_f(); tag = "R6"; end
      end
    end else begin
      tag = (s == hi_lim_f() - 1) ? "R4" : "R7"; exp_cnt = 0;
    end
    if (force_tag != "") tag = force_tag;
    check(tag, int'(cur_scale), exp_cur);
    @(negedge clk);
  endtask

  task automatic smp(input int v, input logic vld, input string t);
    smp_val = 10'(v); smp_vld = vld;
    tick(t);
  endtask

  task automatic cfg(input int lo, input int ofs, input int dec, input int inc,
                     input logic ms, input int ce);
    // pass through the off state so the model restarts from the ceiling
    cfg_lo_thr = 4'd0; cfg_ceil = 5'(ce); smp_vld = 1'b0;
    tick("R2");
    cfg_hi_ofs = 4'(ofs); cfg_dec_spd = 2'(dec); cfg_inc_sel = 2'(inc);
    cfg_min_sel = ms; cfg_lo_thr = 4'(lo);
    smp(0, 1'b0, "R2");
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    int hi;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst = 1'b1; cfg_lo_thr = 4'd3; cfg_hi_ofs = 4'd2; cfg_dec_spd = 2'b11;
    cfg_inc_sel = 2'b00; cfg_min_sel = 1'b0; cfg_ceil = 5'd20;
    smp_val = 10'd0; smp_vld = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1", int'(cur_scale), 20);
    rst = 1'b0; exp_cur = 20; exp_cnt = 0;
    smp(0, 1'b0, "R1");

    // R4 threshold edges, speed code 11 (one hit per decrement); hi = 6*32 = 192
    smp(191, 1'b1, "R4");
    smp(192, 1'b1, "R4");
    smp(200, 1'b1, "R5");
    // R3 below lower threshold (96): step codes 1,2,4,8 and saturation
    for (int c = 0; c < 4; c++) begin
      cfg_inc_sel = 2'(c);
      smp(95, 1'b1, "R3");
      smp(300, 1'b1, "R5");
      smp(300, 1'b1, "R5");
    end
    cfg_inc_sel = 2'b11;
    smp(0, 1'b1, "R3");
    smp(0, 1'b1, "R3");
    // R8 invalid low sample ignored
    smp(0, 1'b0, "R8");

    // R6 floors: ceiling 31 half -> 15, quarter -> 7; ceiling 0 -> 0
    cfg(2, 0, 3, 0, 1'b0, 31);
    for (int i = 0; i < 20; i++) smp(900, 1'b1, "");
    check("R6", int'(cur_scale), 15);
    cfg(2, 0, 3, 0, 1'b1, 31);
    for (int i = 0; i < 30; i++) smp(900, 1'b1, "");
    check("R6", int'(cur_scale), 7);
    cfg(1, 0, 3, 0, 1'b1, 0);
    smp(900, 1'b1, "R6");

    // R5 / R7 run lengths per speed code, broken by a middle sample
    for (int d = 0; d < 4; d++) begin
      cfg(4, 3, d, 0, 1'b1, 28);
      hi = hi_lim_f();
      for (int i = 0; i < 5; i++) smp(hi + 10, 1'b1, "");
      smp(hi - 5, 1'b1, "R7");
      for (int i = 0; i < 40; i++) begin
        smp(hi + 3, 1'b1, "");
        if ((i % 9) == 4) smp(hi, 1'b0, "R8");
      end
    end

    // constrained random episodes
    for (int e = 0; e < 60; e++) begin
      cfg(1 + ($urandom % 15), $urandom % 16, $urandom % 4, $urandom % 4,
          1'($urandom % 2), $urandom % 32);
      for (int i = 0; i < 300; i++) begin
        int r;
        int v;
        r = $urandom % 100;
        if (r < 10)      v = $urandom % (lo_lim_f() > 0 ? lo_lim_f() : 1);
        else if (r < 25) v = lo_lim_f() + ($urandom % (hi_lim_f() - lo_lim_f()));
        else             v = hi_lim_f() + ($urandom % (1024 - hi_lim_f() + 1));
        if (v > 1023) v = 1023;
        smp(v, 1'($urandom % 8 != 0), "");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule